// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Front End

This block is the serial-bus side of a byte-wide nonvolatile memory. It accepts a clock and data pair that the surrounding logic has already brought into the system clock domain, and finds START and STOP conditions on them. It matches a seven-bit device address and splits it into a fixed four-bit prefix, one area-select bit and two strap bits. A write session loads a two-byte memory address, and up to one page of data is then gathered in a small buffer. The STOP that closes the session hands that page to the memory port as one burst of byte writes. A programmable busy interval follows, and for that whole interval the block refuses every device address, so a master can poll until the block answers again.

Reads come from the internal address counter. A read that follows a START directly continues from wherever the counter points. A read that follows a repeated START after the two address bytes starts at the address just loaded. The counter advances after each byte and rolls over from the top of memory to zero. The memory side is a plain synchronous port with one cycle of read latency and a separate area-select line, so the user array and the system array can share one address bus.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the block releases SDA (`sda_oe_o`=0), `busy_o` is 0 and no memory write is issued.
- R2: The block acknowledges a device address byte only when bits 7:4 equal 1010 and bits 2:1 equal `strap_i`, and only while not busy. Bit 3 is the area select and bit 0 is the direction (1 = read). Any other address byte gets no acknowledge.
- R3: Every byte the master sends after an accepted device address (both memory address bytes and all data bytes) is acknowledged by pulling SDA low during the 9th SCL pulse.
- R4: A write session keeps up to PAGE_BYTES (4) data bytes. Each byte goes to the slot given by the low two address bits, and those bits advance and wrap inside the page, so later bytes overwrite earlier ones. The closing STOP issues one write for each filled slot, at most 4, all to the same page and area.
- R5: `busy_o` rises right after the STOP that commits a write and stays high for exactly BUSY_CYCLES clock cycles. While it is high the block drives no acknowledge, so device addresses are refused. After it falls, addresses are accepted again.
- R6: A read issued right after a START, with no address phase, returns the byte at the current internal address.
- R7: While the master acknowledges read bytes, the block sends successive bytes. The address wraps from 8191 back to 0. A master NACK followed by STOP ends the read.
- R8: A repeated START after the two address bytes, followed by a read device address, returns data starting at the address just loaded.
- R9: Device address bit 3 selects the array, with 0 for the user area and 1 for the system area. It appears on `mem_area_o` for both reads and writes, and the two areas keep separate contents.
- R10: A STOP in the middle of a byte, or any START during a write session, discards the buffered data with no memory write and no busy interval.
- R11: The top three bits of the first memory address byte have no effect on the selected address.
- R12: The block changes SDA only while SCL is low, and a driven data bit holds steady through the whole high phase of SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 2 | Board strap value that device address bits 2:1 must match |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (resolved bus level) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_addr_o | output | AW (13) | Memory byte address |
| mem_area_o | output | 1 | 0 = user array, 1 = system array |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe, one byte per cycle |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the address |
| busy_o | output | 1 | High while a committed write is in progress |

## Verification
The assertions assume that SCL and SDA arrive already synchronised and free of glitches. They also assume that SDA from the master moves only while SCL is low, except when it forms START and STOP. A further assumption is that a master never signals STOP or START while the slave is pulling SDA low. The bench drives the bus with quarter-period steps of several system clocks. It changes its own data only after SCL has fallen and releases the line before every slave slot, so every bus event is legal. Its memory model answers with one cycle of latency, which is the timing the block expects from the port.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

    // Fixed upper nibble of the device address byte.
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    // Protocol phase of the slave.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DEV   = 3'd1,
        ST_AHI   = 3'd2,
        ST_ALO   = 3'd3,
        ST_WDATA = 3'd4,
        ST_RDATA = 3'd5
    } phase_e;

endpackage

// File: rtl/i2c_bus_mon.sv
// Edge and bus-condition detector on pre-synchronised SCL/SDA.
module i2c_bus_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d.scl = scl_i;
        mon_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '{scl: 1'b1, sda: 1'b1};
        else        mon_q <= mon_d;
    end

    assign scl_rise_o = scl_i & ~mon_q.scl;
    assign scl_fall_o = ~scl_i & mon_q.scl;
    // SDA falling with SCL high on both samples
    assign start_o    = scl_i & mon_q.scl & mon_q.sda & ~sda_i;
    // SDA rising with SCL high on both samples
    assign stop_o     = scl_i & mon_q.scl & ~mon_q.sda & sda_i;

endmodule

// File: rtl/i2c_busy_timer.sv
// Write-busy interval counted in system clock cycles.
module i2c_busy_timer #(
    parameter int BUSY_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    output logic busy_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (launch_i)          cnt_d = CW'(BUSY_CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
        else                   cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/i2c_page_buf.sv
// Page write buffer: collects bytes by slot, then drains filled slots
// to the memory port one per cycle.
module i2c_page_buf #(
    parameter int AW         = 13,
    parameter int PAGE_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  wr_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] slot_i,
    input  logic [7:0]            byte_i,
    input  logic [AW-$clog2(PAGE_BYTES):0] base_i,
    input  logic                  commit_i,
    output logic                  any_o,
    output logic                  drain_o,
    output logic                  we_o,
    output logic [AW-1:0]         waddr_o,
    output logic                  warea_o,
    output logic [7:0]            wdata_o
);
    localparam int PW     = $clog2(PAGE_BYTES);
    localparam int BASE_W = AW - PW + 1;

    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      valid;
        logic [BASE_W-1:0]          base;
        logic                       drain;
        logic [PW-1:0]              ptr;
    } pbuf_t;

    pbuf_t pb_d, pb_q;
    logic [PAGE_BYTES-1:0] slot_hit;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        assign slot_hit[g] = wr_i && (slot_i == PW'(g));
    end

    always_comb begin
        pb_d = pb_q;
        if (!pb_q.drain) begin
            if (clr_i) pb_d.valid = '0;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (slot_hit[i]) begin
                    pb_d.data[i]  = byte_i;
                    pb_d.valid[i] = 1'b1;
                end
            end
            if (wr_i) pb_d.base = base_i;
            if (commit_i && (pb_q.valid != '0)) begin
                pb_d.drain = 1'b1;
                pb_d.ptr   = '0;
            end
        end else begin
            pb_d.ptr = pb_q.ptr + PW'(1);
            if (pb_q.ptr == PW'(PAGE_BYTES - 1)) begin
                pb_d.drain = 1'b0;
                pb_d.valid = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pb_q <= '0;
        else        pb_q <= pb_d;
    end

    assign any_o   = (pb_q.valid != '0);
    assign drain_o = pb_q.drain;
    assign we_o    = pb_q.drain & pb_q.valid[pb_q.ptr];
    assign waddr_o = {pb_q.base[BASE_W-2:0], pb_q.ptr};
    assign warea_o = pb_q.base[BASE_W-1];
    assign wdata_o = pb_q.data[pb_q.ptr];

endmodule

// File: rtl/i2c_eeprom_slave.sv
// Two-wire EEPROM slave: framing, ACK, address counter, page write, busy.
module i2c_eeprom_slave
    import i2c_eep_pkg::*;
#(
    parameter int AW          = 13,
    parameter int PAGE_BYTES  = 4,
    parameter int BUSY_CYCLES = 5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    strap_i,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_area_o,
    output logic [7:0]    mem_wdata_o,
    output logic          mem_we_o,
    input  logic [7:0]    mem_rdata_i,
    output logic          busy_o
);
    localparam int PW     = $clog2(PAGE_BYTES);
    localparam int HI_W   = AW - 8;
    localparam int BASE_W = AW - PW + 1;

    typedef struct packed {
        phase_e        phase;
        logic [3:0]    bits;
        logic [7:0]    shreg;
        logic          oe;
        logic          rw;
        logic          mack;
        logic          area;
        logic [AW-1:0] addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic buf_clr, buf_wr, commit;
    logic buf_any, buf_drain, buf_we, buf_warea, tmr_busy;
    logic [AW-1:0] buf_waddr;
    logic [7:0]    buf_wdata;
    logic          dev_match;

    i2c_bus_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_page_buf #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (buf_clr),
        .wr_i     (buf_wr),
        .slot_i   (ctl_q.addr[PW-1:0]),
        .byte_i   (ctl_q.shreg),
        .base_i   ({ctl_q.area, ctl_q.addr[AW-1:PW]}),
        .commit_i (commit),
        .any_o    (buf_any),
        .drain_o  (buf_drain),
        .we_o     (buf_we),
        .waddr_o  (buf_waddr),
        .warea_o  (buf_warea),
        .wdata_o  (buf_wdata)
    );

    i2c_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (commit),
        .busy_o   (tmr_busy)
    );

    assign busy_o    = tmr_busy | buf_drain;
    assign dev_match = (ctl_q.shreg[7:4] == DEV_PREFIX) &&
                       (ctl_q.shreg[2:1] == strap_i) && !busy_o;

    always_comb begin
        ctl_d   = ctl_q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        commit  = 1'b0;

        if (start_det) begin
            ctl_d.phase = ST_DEV;
            ctl_d.bits  = '0;
            ctl_d.oe    = 1'b0;
            buf_clr     = 1'b1;
        end else if (stop_det) begin
            // A STOP right after an ACK slot shows one sampled bit at most.
            if (ctl_q.phase == ST_WDATA && ctl_q.bits <= 4'd1 && buf_any)
                commit = 1'b1;
            else
                buf_clr = 1'b1;
            ctl_d.phase = ST_IDLE;
            ctl_d.bits  = '0;
            ctl_d.oe    = 1'b0;
        end else begin
            unique case (ctl_q.phase)
                ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
                    if (scl_rise && ctl_q.bits < 4'd8) begin
                        ctl_d.shreg = {ctl_q.shreg[6:0], sda_i};
                        ctl_d.bits  = ctl_q.bits + 4'd1;
                    end else if (scl_fall && ctl_q.bits == 4'd8) begin
                        ctl_d.bits = 4'd9;
                        unique case (ctl_q.phase)
                            ST_DEV: begin
                                if (dev_match) begin
                                    ctl_d.oe   = 1'b1;
                                    ctl_d.area = ctl_q.shreg[3];
                                    ctl_d.rw   = ctl_q.shreg[0];
                                end else begin
                                    ctl_d.phase = ST_IDLE;
                                    ctl_d.bits  = '0;
                                end
                            end
                            ST_AHI: begin
                                ctl_d.oe             = 1'b1;
                                ctl_d.addr[AW-1:8]   = ctl_q.shreg[HI_W-1:0];
                            end
                            ST_ALO: begin
                                ctl_d.oe        = 1'b1;
                                ctl_d.addr[7:0] = ctl_q.shreg;
                            end
                            default: begin
                                ctl_d.oe            = 1'b1;
                                buf_wr              = 1'b1;
                                ctl_d.addr[PW-1:0]  = ctl_q.addr[PW-1:0] + PW'(1);
                            end
                        endcase
                    end else if (scl_fall && ctl_q.bits == 4'd9) begin
                        ctl_d.oe   = 1'b0;
                        ctl_d.bits = '0;
                        unique case (ctl_q.phase)
                            ST_DEV: begin
                                if (ctl_q.rw) begin
                                    ctl_d.phase = ST_RDATA;
                                    ctl_d.shreg = mem_rdata_i;
                                    ctl_d.oe    = ~mem_rdata_i[7];
                                    ctl_d.addr  = ctl_q.addr + AW'(1);
                                end else begin
                                    ctl_d.phase = ST_AHI;
                                end
                            end
                            ST_AHI:  ctl_d.phase = ST_ALO;
                            ST_ALO:  ctl_d.phase = ST_WDATA;
                            default: ctl_d.phase = ST_WDATA;
                        endcase
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        if (ctl_q.bits == 4'd8) begin
                            ctl_d.mack = ~sda_i;
                            ctl_d.bits = 4'd9;
                        end else if (ctl_q.bits < 4'd8) begin
                            ctl_d.bits = ctl_q.bits + 4'd1;
                        end
                    end else if (scl_fall) begin
                        if (ctl_q.bits >= 4'd1 && ctl_q.bits <= 4'd7) begin
                            ctl_d.shreg = {ctl_q.shreg[6:0], 1'b0};
                            ctl_d.oe    = ~ctl_q.shreg[6];
                        end else if (ctl_q.bits == 4'd8) begin
                            ctl_d.oe = 1'b0;
                        end else if (ctl_q.bits == 4'd9) begin
                            ctl_d.bits = '0;
                            if (ctl_q.mack) begin
                                ctl_d.shreg = mem_rdata_i;
                                ctl_d.oe    = ~mem_rdata_i[7];
                                ctl_d.addr  = ctl_q.addr + AW'(1);
                            end else begin
                                ctl_d.phase = ST_IDLE;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sda_oe_o    = ctl_q.oe;
    assign mem_we_o    = buf_we;
    assign mem_wdata_o = buf_wdata;
    assign mem_addr_o  = buf_drain ? buf_waddr : ctl_q.addr;
    assign mem_area_o  = buf_drain ? buf_warea : ctl_q.area;

endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk #(
    parameter int AW         = 13,
    parameter int PAGE_BYTES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe_o,
    input logic          busy_o,
    input logic          mem_we_o,
    input logic          mem_area_o,
    input logic [AW-1:0] mem_addr_o
);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [3:0] wr_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wr_cnt_q <= '0;
        else if (!busy_o)  wr_cnt_q <= '0;
        else if (mem_we_o) wr_cnt_q <= wr_cnt_q + 4'd1;
    end

    // R12: slave output frozen while SCL stays high
    a_r12_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

    // R5: no acknowledge or data drive during the busy interval
    a_r5_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o);

    // R4: memory writes only happen inside a busy interval
    a_r4_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R4: at most one page of writes per busy interval
    a_r4_one_page_per_commit: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wr_cnt_q) <= PAGE_BYTES);

    // R9: back-to-back writes stay in one page of one area
    a_r9_burst_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |->
        ($stable(mem_area_o) && ($past(mem_addr_o[AW-1:PW]) == mem_addr_o[AW-1:PW])));

endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o),
    .mem_area_o (mem_area_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;
    localparam int AW   = 13;
    localparam int PB   = 4;
    localparam int BUSY = 400;
    localparam int Q    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]    strap = 2'b10;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_line;
    logic          sda_oe;
    logic [AW-1:0] mem_addr;
    logic          mem_area;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic [7:0]    mem_rdata;
    logic          busy;

    assign sda_line = sda_m & ~sda_oe;

    i2c_eeprom_slave #(.AW(AW), .PAGE_BYTES(PB), .BUSY_CYCLES(BUSY)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .mem_addr_o  (mem_addr),
        .mem_area_o  (mem_area),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_rdata_i (mem_rdata),
        .busy_o      (busy)
    );

    // memory model with one cycle of read latency
    logic [7:0] mem   [int];
    logic [7:0] expm  [int];
    int  we_cnt = 0;
    logic last_we_area = 1'b0;
    int  busy_run = 0;
    int  last_busy = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  done = 0;
    logic [AW-1:0] cur_addr = '0;

    function automatic int key(input logic area, input logic [AW-1:0] a);
        return int'({area, a});
    endfunction

    always @(posedge clk) begin
        if (mem_we) begin
            mem[key(mem_area, mem_addr)] = mem_wdata;
            we_cnt++;
            last_we_area = mem_area;
        end
        mem_rdata <= mem.exists(key(mem_area, mem_addr)) ? mem[key(mem_area, mem_addr)] : 8'hFF;
        if (busy) busy_run++;
        else if (busy_run != 0) begin
            last_busy = busy_run;
            busy_run  = 0;
        end
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog all-reqs: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] exp_byte(input logic area, input logic [AW-1:0] a);
        return expm.exists(key(area, a)) ? expm[key(area, a)] : 8'hFF;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic qwait;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; qwait;
        scl_m = 1'b1; qwait;
        sda_m = 1'b0; qwait;
        scl_m = 1'b0; qwait;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; qwait;
        scl_m = 1'b1; qwait;
        sda_m = 1'b1; qwait;
    endtask

    task automatic clock_bit(input logic b);
        sda_m = b; qwait;
        scl_m = 1'b1; qwait; qwait;
        scl_m = 1'b0; qwait;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) clock_bit(b[i]);
        sda_m = 1'b1; qwait;
        scl_m = 1'b1; qwait;
        acked = ~sda_line;
        qwait;
        scl_m = 1'b0; qwait;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack);
        logic s1;
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            qwait;
            scl_m = 1'b1; qwait;
            s1 = sda_line;
            b = {b[6:0], s1};
            qwait;
            chk("R12", "data held during SCL high", 32'(sda_line), 32'(s1));
            scl_m = 1'b0;
        end
        qwait;
        sda_m = ~ack; qwait;
        scl_m = 1'b1; qwait; qwait;
        scl_m = 1'b0; qwait;
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input logic area, input logic [1:0] st, input logic rd);
        return {4'b1010, area, st, rd};
    endfunction

    task automatic wait_idle;
        for (int g = 0; g < BUSY * 4 && busy; g++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // write session; the high address byte carries junk in its top bits (R11)
    task automatic write_session(input logic area, input logic [AW-1:0] a,
                                 input int n, input logic [7:0] seed);
        logic ack, all_ack;
        logic [AW-1:0] wa;
        we_cnt = 0;
        all_ack = 1'b1;
        bus_start;
        send_byte(dev_byte(area, strap, 1'b0), ack); all_ack &= ack;
        send_byte({3'b101, a[12:8]}, ack);            all_ack &= ack;
        send_byte(a[7:0], ack);                        all_ack &= ack;
        for (int i = 0; i < n; i++) begin
            send_byte(seed + 8'(i * 17), ack);
            all_ack &= ack;
            wa = {a[AW-1:2], 2'(a[1:0] + 2'(i))};
            expm[key(area, wa)] = seed + 8'(i * 17);
        end
        bus_stop;
        cur_addr = {a[AW-1:2], 2'(a[1:0] + 2'(n))};
        chk("R3", "all master bytes acknowledged", 32'(all_ack), 32'd1);
        wait_idle;
        chk("R4", "writes issued for session", we_cnt, (n > PB) ? PB : n);
        chk("R5", "busy interval length", last_busy, BUSY);
    endtask

    task automatic read_check(input logic area, input logic [AW-1:0] a, input int n,
                              input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            chk(req, "read byte", 32'(b), 32'(exp_byte(area, AW'(a + AW'(i)))));
        end
        bus_stop;
    endtask

    task automatic random_read(input logic area, input logic [AW-1:0] a, input int n,
                               input string req);
        logic ack, all_ack;
        all_ack = 1'b1;
        bus_start;
        send_byte(dev_byte(area, strap, 1'b0), ack); all_ack &= ack;
        send_byte({3'b000, a[12:8]}, ack);            all_ack &= ack;
        send_byte(a[7:0], ack);                        all_ack &= ack;
        bus_start;
        send_byte(dev_byte(area, strap, 1'b1), ack); all_ack &= ack;
        chk("R8", "random read address phase acked", 32'(all_ack), 32'd1);
        read_check(area, a, n, req);
        cur_addr = AW'(a + AW'(n));
    endtask

    task automatic t_reset;
        chk("R1", "sda released", 32'(sda_oe), 32'd0);
        chk("R1", "busy low", 32'(busy), 32'd0);
        chk("R1", "no write", 32'(mem_we), 32'd0);
    endtask

    task automatic t_address_match;
        logic ack;
        bus_start;
        send_byte(dev_byte(1'b0, 2'b01, 1'b0), ack);
        bus_stop;
        chk("R2", "strap mismatch nacked", 32'(ack), 32'd0);
        bus_start;
        send_byte({4'b1011, 1'b0, strap, 1'b0}, ack);
        bus_stop;
        chk("R2", "prefix mismatch nacked", 32'(ack), 32'd0);
        bus_start;
        send_byte(dev_byte(1'b0, strap, 1'b0), ack);
        bus_stop;
        chk("R2", "matching address acked", 32'(ack), 32'd1);
    endtask

    task automatic t_busy_poll;
        logic ack;
        we_cnt = 0;
        bus_start;
        send_byte(dev_byte(1'b0, strap, 1'b0), ack);
        send_byte(8'h01, ack);
        send_byte(8'h05, ack);
        send_byte(8'hA0, ack);
        send_byte(8'hB1, ack);
        bus_stop;
        expm[key(1'b0, 13'h0105)] = 8'hA0;
        expm[key(1'b0, 13'h0106)] = 8'hB1;
        cur_addr = 13'h0107;
        bus_start;
        send_byte(dev_byte(1'b0, strap, 1'b0), ack);
        bus_stop;
        chk("R5", "address refused while busy", 32'(ack), 32'd0);
        chk("R5", "busy high after commit", 32'(busy), 32'd1);
        wait_idle;
        chk("R5", "busy interval length", last_busy, BUSY);
        chk("R4", "two writes for two bytes", we_cnt, 2);
        bus_start;
        send_byte(dev_byte(1'b0, strap, 1'b0), ack);
        bus_stop;
        chk("R5", "address accepted after busy", 32'(ack), 32'd1);
    endtask

    task automatic t_current_read;
        logic ack;
        random_read(1'b0, 13'h0105, 1, "R8");
        bus_start;
        send_byte(dev_byte(1'b0, strap, 1'b1), ack);
        chk("R6", "current read acked", 32'(ack), 32'd1);
        read_check(1'b0, 13'h0106, 1, "R6");
    endtask

    task automatic t_abort;
        logic ack;
        logic [7:0] b;
        we_cnt = 0;
        bus_start;
        send_byte(dev_byte(1'b0, strap, 1'b0), ack);
        send_byte(8'h03, ack);
        send_byte(8'h40, ack);
        send_byte(8'h99, ack);
        for (int i = 0; i < 4; i++) clock_bit(1'b1);
        bus_stop;
        repeat (20) @(negedge clk);
        chk("R10", "mid-byte stop no busy", 32'(busy), 32'd0);
        chk("R10", "mid-byte stop no write", we_cnt, 0);
        bus_start;
        send_byte(dev_byte(1'b0, strap, 1'b0), ack);
        send_byte(8'h03, ack);
        send_byte(8'h40, ack);
        send_byte(8'h55, ack);
        bus_start;
        send_byte(dev_byte(1'b0, strap, 1'b1), ack);
        recv_byte(b, 1'b0);
        bus_stop;
        repeat (20) @(negedge clk);
        chk("R10", "restart discards data", 32'(b), 32'(exp_byte(1'b0, 13'h0340)));
        chk("R10", "restart no write", we_cnt, 0);
        chk("R10", "restart no busy", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset;

        t_address_match;
        t_busy_poll;
        random_read(1'b0, 13'h0105, 2, "R7");
        t_current_read;

        // page wrap: 6 bytes from offset 2 land in slots 2,3,0,1,2,3
        write_session(1'b0, 13'h0206, 6, 8'h10);
        random_read(1'b0, 13'h0204, 4, "R4");
        chk("R4", "slot 0 holds third byte", 32'(exp_byte(1'b0, 13'h0204)), 32'h32);

        // top-of-memory wrap
        write_session(1'b0, 13'h1FFF, 1, 8'h5A);
        write_session(1'b0, 13'h0000, 1, 8'h3C);
        random_read(1'b0, 13'h1FFF, 2, "R7");

        // area select
        write_session(1'b1, 13'h0005, 1, 8'h77);
        chk("R9", "write went to system area", 32'(last_we_area), 32'd1);
        random_read(1'b0, 13'h0005, 1, "R9");
        random_read(1'b1, 13'h0005, 1, "R9");
        chk("R11", "junk high bits ignored", 32'(exp_byte(1'b1, 13'h0005)), 32'h77);

        t_abort;

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule